// File: doc/BRIEF.md
# Flash Page Program Buffer

This block is the page-program part of a serial flash slave. It watches the select line and a per-bit strobe from the serial front end, and decodes the first byte of each frame as an opcode. When the opcode is one of the two program opcodes and the status controller allows programming, the block takes a 24-bit address. It then gathers data bytes into a 256-byte staging buffer that starts each frame filled with ones. The programming lane width is one bit, or four bits once the address is in.

When select is released on a clean byte boundary and the target sector is not locked, a commit engine walks the addressed page. It ANDs each stored byte with its staged byte, so programming can only clear bits. The status controller receives a one-cycle commit strobe; it uses the strobe to drop its write-enable latch and start its own program timer. A rejected frame gives an error strobe and leaves the array untouched.

The array depth and the sector size are parameters, so a small array can stand in for a full device. Address bits above the array size are ignored, which makes the array alias.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, quad_mode, busy, commit_stb and err_stb are low and every array byte reads 0xFF.
- R2: A frame is taken only if its first byte (MSB first, one bit per strobe) is 0x02 or 0x32 while prog_allow is high and busy is low. Any other frame gives no commit, no error and no array change.
- R3: The next three bytes form the address, high byte first. Taking the address sets all 256 staging bytes to 0xFF, so page bytes that no data byte touches keep their old values.
- R4: Each data byte is staged at the column given by address bits [7:0]. The column then increments and wraps from 0xFF to 0x00, while the page bits stay fixed.
- R5: On commit, each byte of the page (address bits [7:0] forced to zero) becomes its old value ANDed with the staged byte at the same column.
- R6: For opcode 0x32, quad_mode rises on the strobe that completes the address. Each later strobe then carries four bits on din[3:0], high nibble first. quad_mode is low whenever select is high.
- R7: A taken frame that ends off a byte boundary, or before its address is complete, raises err_stb for one cycle. It gives no commit and no array change.
- R8: A taken frame whose sector_lock bit is set raises err_stb and leaves the array unchanged. The bit is indexed by address bits [MEM_AW-1:SECT_AW], which is bit 9 by default.
- R9: A valid frame end raises commit_stb for exactly one cycle, at the first clock edge that samples cs_n high. busy goes high at that same edge and stays high for 256 cycles.
- R10: While busy is high, no new frame is taken, so a frame sent during a commit changes nothing and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| bit_stb | input | 1 | One-cycle strobe: din holds the next serial bit or nibble |
| din | input | 4 | Serial data; din[0] in single-bit phase |
| prog_allow | input | 1 | Status controller permits programming |
| sector_lock | input | NSECT | One lock bit per sector |
| rd_addr | input | MEM_AW | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| quad_mode | output | 1 | Four-bit data phase active |
| commit_stb | output | 1 | Commit started; the status controller clears write enable and starts its timer |
| err_stb | output | 1 | Taken frame rejected |
| busy | output | 1 | Commit engine running |

## Verification
commit_stb, err_stb and the rise of busy are all due on the first edge that sees cs_n high. The bench therefore samples them at the next falling edge, and it counts the falling edges that see busy high, expecting 256. quad_mode is due on the edge that latches the 32nd bit and is read at the falling edge right after that strobe. Array contents are final only when busy falls. The bench waits for that before its scoreboard monitor compares every byte of the touched pages against a model built from the requirements.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  localparam int PAGE_BYTES = 256;
  localparam logic [7:0] OP_PROG_SINGLE = 8'h02;
  localparam logic [7:0] OP_PROG_QUAD   = 8'h32;

  function automatic logic is_prog_op(input logic [7:0] op);
    return (op == OP_PROG_SINGLE) || (op == OP_PROG_QUAD);
  endfunction

  function automatic logic [7:0] next_col(input logic [7:0] col);
    return col + 8'd1;
  endfunction

  function automatic logic [2:0] advance_pos(input logic [2:0] pos, input logic wide);
    return pos + (wide ? 3'd4 : 3'd1);
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic [3:0] d,
                                          input logic wide);
    return wide ? {sh[3:0], d} : {sh[6:0], d[0]};
  endfunction
endpackage

// File: rtl/fpp_frame.sv
module fpp_frame
  import fpp_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          bit_stb,
  input  logic [3:0]    din,
  input  logic          cmd_ok,
  output logic [AW-1:0] addr,
  output logic          quad,
  output logic          fill_evt,
  output logic          byte_evt,
  output logic [7:0]    byte_val,
  output logic          end_evt,
  output logic          frame_live,
  output logic          frame_good
);
  logic       cs_q, active, qsel;
  logic [2:0] bitpos, nbytes;
  logic [7:0] sh, nb;
  logic [2:0] newpos;
  logic       step, byte_done;

  always_comb begin
    step      = bit_stb & ~cs_n;
    nb        = shift_in(sh, din, quad);
    newpos    = advance_pos(bitpos, quad);
    byte_done = step && (newpos == 3'd0);
    fill_evt  = byte_done & active & (nbytes == 3'd3);
    byte_evt  = byte_done & active & (nbytes == 3'd4);
    byte_val  = nb;
    end_evt   = cs_n & ~cs_q;
    frame_live = active;
    frame_good = active && (nbytes == 3'd4) && (bitpos == 3'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1; active <= 1'b0; qsel <= 1'b0; quad <= 1'b0;
      bitpos <= '0; nbytes <= '0; sh <= '0; addr <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        active <= 1'b0; qsel <= 1'b0; quad <= 1'b0;
        bitpos <= '0; nbytes <= '0; sh <= '0;
      end else if (step) begin
        sh     <= nb;
        bitpos <= newpos;
        if (byte_done) begin
          if (nbytes != 3'd4) nbytes <= nbytes + 3'd1;
          case (nbytes)
            3'd0: begin
              active <= is_prog_op(nb) && cmd_ok;
              qsel   <= (nb == OP_PROG_QUAD);
            end
            3'd1, 3'd2: addr <= AW'({addr, nb});
            3'd3: begin
              addr <= AW'({addr, nb});
              quad <= active & qsel;
            end
            default: if (active) addr <= {addr[AW-1:8], next_col(addr[7:0])};
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fpp_stage.sv
module fpp_stage
  import fpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fill,
  input  logic       wr,
  input  logic [7:0] wr_idx,
  input  logic [7:0] wr_val,
  input  logic [7:0] rd_idx,
  output logic [7:0] rd_val
);
  logic [7:0] stg [PAGE_BYTES];

  assign rd_val = stg[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || fill) begin
      for (int i = 0; i < PAGE_BYTES; i++) stg[i] <= 8'hFF;
    end else if (wr) begin
      stg[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/fpp_commit.sv
module fpp_commit #(
  parameter int MEM_BYTES = 1024,
  parameter int AW        = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-9:0] page,
  output logic [7:0]    buf_idx,
  input  logic [7:0]    buf_byte,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy
);
  logic [7:0]    mem [MEM_BYTES];
  logic [AW-9:0] page_q;
  logic [7:0]    idx;

  assign buf_idx = idx;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; page_q <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (start && !busy) begin
      busy <= 1'b1; idx <= '0; page_q <= page;
    end else if (busy) begin
      mem[{page_q, idx}] <= mem[{page_q, idx}] & buf_byte;
      idx <= idx + 8'd1;
      if (idx == 8'hFF) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog #(
  parameter int MEM_BYTES = 1024,
  parameter int SECT_AW   = 9,
  localparam int MEM_AW   = $clog2(MEM_BYTES),
  localparam int NSECT    = 1 << (MEM_AW - SECT_AW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_stb,
  input  logic [3:0]        din,
  input  logic              prog_allow,
  input  logic [NSECT-1:0]  sector_lock,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              quad_mode,
  output logic              commit_stb,
  output logic              err_stb,
  output logic              busy
);
  logic [MEM_AW-1:0] addr;
  logic fill_evt, byte_evt, end_evt, frame_live, frame_good;
  logic lock_hit, commit_start, err_now;
  logic [7:0] byte_val, buf_idx, buf_byte;

  fpp_frame #(.AW(MEM_AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .din(din),
    .cmd_ok(prog_allow & ~busy), .addr(addr), .quad(quad_mode),
    .fill_evt(fill_evt), .byte_evt(byte_evt), .byte_val(byte_val),
    .end_evt(end_evt), .frame_live(frame_live), .frame_good(frame_good)
  );

  fpp_stage u_stage (
    .clk(clk), .rst_n(rst_n), .fill(fill_evt), .wr(byte_evt),
    .wr_idx(addr[7:0]), .wr_val(byte_val), .rd_idx(buf_idx), .rd_val(buf_byte)
  );

  assign lock_hit     = sector_lock[addr[MEM_AW-1:SECT_AW]];
  assign commit_start = end_evt & frame_good & ~lock_hit;
  assign err_now      = end_evt & frame_live & ~(frame_good & ~lock_hit);

  fpp_commit #(.MEM_BYTES(MEM_BYTES), .AW(MEM_AW)) u_commit (
    .clk(clk), .rst_n(rst_n), .start(commit_start), .page(addr[MEM_AW-1:8]),
    .buf_idx(buf_idx), .buf_byte(buf_byte), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_stb <= 1'b0; err_stb <= 1'b0;
    end else begin
      commit_stb <= commit_start;
      err_stb    <= err_now;
    end
  end
endmodule

// File: rtl/fpp_checks.sv
module fpp_checks (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic commit_stb,
  input logic err_stb,
  input logic busy,
  input logic quad_mode,
  input logic byte_evt,
  input logic fill_evt
);
  assert_commit_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> !commit_stb);
  assert_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |=> busy);
  assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_stb && err_stb));
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_stb |=> !err_stb);
  assert_no_byte_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |-> !busy);
  assert_no_fill_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |-> !busy);
  assert_quad_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !quad_mode);
endmodule

bind flash_page_prog fpp_checks u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .commit_stb(commit_stb),
  .err_stb(err_stb), .busy(busy), .quad_mode(quad_mode),
  .byte_evt(byte_evt), .fill_evt(fill_evt)
);

// File: tb/flash_page_prog_test.sv
`timescale 1ns/1ps
module flash_page_prog_test;
  localparam int MB = 1024;
  logic clk = 0, rst_n = 0, cs_n = 1, bit_stb = 0, prog_allow = 1;
  logic [3:0] din = 0;
  logic [1:0] sector_lock = 0;
  logic [9:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic quad_mode, commit_stb, err_stb, busy;

  flash_page_prog uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_stb(bit_stb), .din(din),
    .prog_allow(prog_allow), .sector_lock(sector_lock), .rd_addr(rd_addr),
    .rd_data(rd_data), .quad_mode(quad_mode), .commit_stb(commit_stb),
    .err_stb(err_stb), .busy(busy)
  );

  always #2.5 clk = ~clk;

  typedef struct { int addr; logic [7:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0, n_commit = 0, n_err = 0;
  logic [7:0] model [MB];
  logic [7:0] pay [16];
  logic quad_seen;

  always @(posedge clk) begin
    if (commit_stb) n_commit <= n_commit + 1;
    if (err_stb) n_err <= n_err + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rd_addr = it.addr[9:0];
        #1;
        chk(rd_data === it.exp, it.req, "array byte", int'(rd_data), int'(it.exp));
      end
    end
  end

  task automatic send_bit(input logic [3:0] d);
    @(negedge clk); din = d; bit_stb = 1;
    @(negedge clk); bit_stb = 0;
  endtask

  task automatic send_ser(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit({3'b000, b[i]});
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [23:0] a,
                       input int n, input int extra);
    bit wide;
    wide = (cmd == 8'h32);
    @(negedge clk); cs_n = 0;
    send_ser(cmd); send_ser(a[23:16]); send_ser(a[15:8]); send_ser(a[7:0]);
    quad_seen = quad_mode;
    for (int k = 0; k < n; k++) begin
      if (wide) begin send_bit(pay[k][7:4]); send_bit(pay[k][3:0]); end
      else send_ser(pay[k]);
    end
    for (int e = 0; e < extra; e++) send_bit(wide ? 4'hF : 4'h1);
    @(negedge clk); cs_n = 1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic model_apply(input logic [23:0] a, input int n);
    logic [7:0] stg [256];
    logic [7:0] col;
    int base;
    for (int i = 0; i < 256; i++) stg[i] = 8'hFF;
    col = a[7:0];
    for (int k = 0; k < n; k++) begin stg[col] = pay[k]; col = col + 8'd1; end
    base = int'(a[9:0]) & 32'h300;
    for (int i = 0; i < 256; i++) model[base + i] = model[base + i] & stg[i];
  endtask

  task automatic expect_page(input logic [23:0] a, input string req);
    int base;
    item_t it;
    base = int'(a[9:0]) & 32'h300;
    for (int i = 0; i < 256; i++) begin
      it.addr = base + i; it.exp = model[base + i]; it.req = req;
      q.push_back(it);
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int cc, ce, cnt;
    for (int i = 0; i < MB; i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(quad_mode == 0, "R1", "quad_mode", quad_mode, 0);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(commit_stb == 0 && err_stb == 0, "R1", "strobes", {commit_stb, err_stb}, 0);
    begin
      item_t it;
      it.req = "R1"; it.exp = 8'hFF;
      it.addr = 0; q.push_back(it);
      it.addr = 'h155; q.push_back(it);
      it.addr = 'h3FF; q.push_back(it);
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    // R9 / R3 single-bit program with busy length
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h0F;
    cc = n_commit;
    frame(8'h02, 24'h000010, 3, 0);
    cnt = 0;
    @(negedge clk);
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == 256, "R9", "busy cycles", cnt, 256);
    chk(n_commit == cc + 1, "R9", "commit pulses", n_commit - cc, 1);
    chk(quad_seen == 0, "R6", "quad in single frame", quad_seen, 0);
    model_apply(24'h000010, 3);
    expect_page(24'h000010, "R3");

    // R5 AND semantics
    pay[0] = 8'hF0; pay[1] = 8'hF0;
    frame(8'h02, 24'h000010, 2, 0); settle();
    model_apply(24'h000010, 2);
    expect_page(24'h000010, "R5");

    // R4 column wrap
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
    frame(8'h02, 24'h0001FE, 4, 0); settle();
    model_apply(24'h0001FE, 4);
    expect_page(24'h0001FE, "R4");

    // R6 quad program
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
    frame(8'h32, 24'h000220, 3, 0);
    chk(quad_seen == 1, "R6", "quad after address", quad_seen, 1);
    settle();
    chk(quad_mode == 0, "R6", "quad after frame", quad_mode, 0);
    model_apply(24'h000220, 3);
    expect_page(24'h000220, "R6");

    // R7 off-boundary frame end, single and quad
    pay[0] = 8'h00;
    cc = n_commit; ce = n_err;
    frame(8'h02, 24'h000040, 1, 3); settle();
    chk(n_err == ce + 1, "R7", "err pulses", n_err - ce, 1);
    chk(n_commit == cc, "R7", "commit pulses", n_commit - cc, 0);
    frame(8'h32, 24'h000040, 1, 1); settle();
    chk(n_err == ce + 2, "R7", "quad err pulses", n_err - ce, 2);
    expect_page(24'h000040, "R7");

    // R8 locked sector, then unlocked
    sector_lock = 2'b10;
    cc = n_commit; ce = n_err;
    frame(8'h02, 24'h000300, 1, 0); settle();
    chk(n_err == ce + 1, "R8", "err pulses", n_err - ce, 1);
    chk(n_commit == cc, "R8", "commit pulses", n_commit - cc, 0);
    expect_page(24'h000300, "R8");
    sector_lock = 2'b00;
    frame(8'h02, 24'h000300, 1, 0); settle();
    chk(n_commit == cc + 1, "R8", "commit after unlock", n_commit - cc, 1);
    model_apply(24'h000300, 1);
    expect_page(24'h000300, "R8");

    // R2 wrong opcode, and program not allowed
    cc = n_commit; ce = n_err;
    frame(8'h03, 24'h000050, 1, 0); settle();
    prog_allow = 0;
    frame(8'h02, 24'h000050, 1, 0); settle();
    prog_allow = 1;
    chk(n_commit == cc && n_err == ce, "R2", "strobes",
        (n_commit - cc) + (n_err - ce), 0);
    expect_page(24'h000050, "R2");

    // R10 frame during commit is ignored
    cc = n_commit; ce = n_err;
    frame(8'h02, 24'h000100, 1, 0);
    frame(8'h02, 24'h000000, 1, 0);
    settle();
    chk(n_commit == cc + 1, "R10", "commit pulses", n_commit - cc, 1);
    chk(n_err == ce, "R10", "err pulses", n_err - ce, 0);
    model_apply(24'h000100, 1);
    expect_page(24'h000100, "R10");
    expect_page(24'h000000, "R10");

    finish_up();
  end
endmodule